// File: doc/BRIEF.md
# Prime-Field Shift Register with Word Reorganization

This block holds sixteen 31-bit cells whose values are residues modulo the Mersenne prime p = 2^31-1. Each step adds a weighted sum of five cells, reduced modulo p, and shifts the cells toward cell 0. The weights are powers of two, and a constant weight of 2^k modulo p is a 31-bit left rotation by k. The full feedback is therefore a tree of modular adders fed by rotated copies of the cells, and the whole update fits in one clock cycle.

There are two modes. In initialization mode an external 31-bit value `u_in` enters the feedback sum. In working mode that input takes no part. A parallel load port writes all sixteen cells in one cycle. Four 32-bit words are formed without logic from halves of selected cells. A nonlinear stage and a sequencer outside this block use those words.

Top module: `gfp_lfsr_core`

## Requirements
- R1: While `rst_n` is low, and after it is released, all cells are zero. Until the first load or step, every output word reads 0.
- R2: With `load_en` high, every cell i takes `load_cells[31*i+30 : 31*i]` at the next rising edge.
- R3: When `load_en` and `step_en` are both high, the load takes effect and the step is discarded.
- R4: A step (`step_en` high, `load_en` low) moves cell i+1 into cell i for i = 0..14. The old cell 0 is dropped.
- R5: In working mode (`init_mode` = 0) the new cell 15 is (2^15·s15 + 2^17·s13 + 2^21·s10 + 2^20·s4 + 257·s0) mod p. The value on `u_in` has no effect.
- R6: In initialization mode (`init_mode` = 1) the value `u_in` is added to that sum before reduction.
- R7: A stepped-in cell value always lies in 0..p-1. A sum congruent to 0 gives 0, never 0x7FFFFFFF.
- R8: `x0` = {s15[30:15], s14[15:0]}.
- R9: `x1` = {s11[15:0], s9[30:15]} and `x2` = {s7[15:0], s5[30:15]}.
- R10: `x3` = {s2[15:0], s0[30:15]}.
- R11: With neither `load_en` nor `step_en` high, no cell changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Write all cells from `load_cells` |
| load_cells | input | 496 | Cell i at bits 31*i+30 down to 31*i |
| step_en | input | 1 | Advance the register one position |
| init_mode | input | 1 | 1 = add `u_in` into the feedback |
| u_in | input | 31 | Value added in initialization mode |
| x0 | output | 32 | Reorganized word 0 |
| x1 | output | 32 | Reorganized word 1 |
| x2 | output | 32 | Reorganized word 2 |
| x3 | output | 32 | Reorganized word 3 |

## Verification
Any wrong feedback value shows in the high half of `x0` in the cycle after the faulty step. It then moves down through `x1`, `x2` and `x3` over the following fifteen steps. Cell 0 is visible through `x3`, so a wrong shift or an ignored step also differs from the model within one cycle. The bench compares all four words every cycle against a model built on plain integer arithmetic with a true modulo. Long runs after random loads, operands that wrap past p, and sums congruent to zero expose errors in end-around carry or in zero handling.

// File: rtl/gfp_lfsr_pkg.sv
package gfp_lfsr_pkg;
    localparam int unsigned CELL_W  = 31;
    localparam int unsigned N_CELLS = 16;
    localparam int unsigned HALF_W  = 16;
    localparam int unsigned WORD_W  = 2 * HALF_W;

    typedef logic [CELL_W-1:0] cell_t;
    typedef logic [N_CELLS-1:0][CELL_W-1:0] cell_arr_t;
    typedef logic [WORD_W-1:0] word_t;

    localparam cell_t PRIME = {CELL_W{1'b1}};

    // feedback weight exponents (2^k mod p is a rotation by k)
    localparam int unsigned ROT_S15 = 15;
    localparam int unsigned ROT_S13 = 17;
    localparam int unsigned ROT_S10 = 21;
    localparam int unsigned ROT_S4  = 20;
    localparam int unsigned ROT_S0  = 8;

    typedef struct packed {
        cell_arr_t cells;
    } lfsr_state_t;

    function automatic cell_t rotl_cell(cell_t x, int unsigned k);
        return cell_t'({x, x} >> (CELL_W - k));
    endfunction
endpackage

// File: rtl/gfp_modadd.sv
module gfp_modadd
    import gfp_lfsr_pkg::*;
(
    input  cell_t a_in,
    input  cell_t b_in,
    output cell_t sum_out
);
    logic [CELL_W:0]   raw_sum;
    logic [CELL_W-1:0] folded;

    always_comb begin
        raw_sum = {1'b0, a_in} + {1'b0, b_in};
        // end-around carry: 2^31 is congruent to 1
        folded  = raw_sum[CELL_W-1:0] + CELL_W'(raw_sum[CELL_W]);
        sum_out = (folded == PRIME) ? '0 : folded;
    end
endmodule

// File: rtl/gfp_feedback.sv
module gfp_feedback
    import gfp_lfsr_pkg::*;
#(
    parameter int unsigned N_TERMS = 8
) (
    input  cell_t s15_in,
    input  cell_t s13_in,
    input  cell_t s10_in,
    input  cell_t s4_in,
    input  cell_t s0_in,
    input  cell_t add_in,
    output cell_t fb_out
);
    localparam int unsigned N_NODES = 2 * N_TERMS - 1;
    localparam int unsigned N_ADDS  = N_TERMS - 1;

    cell_t node [N_NODES];
    cell_t term [N_TERMS];

    always_comb begin
        for (int t = 0; t < N_TERMS; t++) term[t] = '0;
        term[0] = rotl_cell(s15_in, ROT_S15);
        term[1] = rotl_cell(s13_in, ROT_S13);
        term[2] = rotl_cell(s10_in, ROT_S10);
        term[3] = rotl_cell(s4_in,  ROT_S4);
        term[4] = rotl_cell(s0_in,  ROT_S0);
        term[5] = s0_in;
        term[6] = add_in;
    end

    genvar gl, ga;
    generate
        for (gl = 0; gl < N_TERMS; gl++) begin : g_leaf
            assign node[N_ADDS + gl] = term[gl];
        end
        for (ga = 0; ga < N_ADDS; ga++) begin : g_add
            gfp_modadd i_add (
                .a_in   (node[2*ga+1]),
                .b_in   (node[2*ga+2]),
                .sum_out(node[ga])
            );
        end
    endgenerate

    assign fb_out = node[0];
endmodule

// File: rtl/gfp_reorg.sv
module gfp_reorg
    import gfp_lfsr_pkg::*;
(
    input  logic [HALF_W-1:0] s15_hi,
    input  logic [HALF_W-1:0] s14_lo,
    input  logic [HALF_W-1:0] s11_lo,
    input  logic [HALF_W-1:0] s9_hi,
    input  logic [HALF_W-1:0] s7_lo,
    input  logic [HALF_W-1:0] s5_hi,
    input  logic [HALF_W-1:0] s2_lo,
    input  logic [HALF_W-1:0] s0_hi,
    output word_t             w0,
    output word_t             w1,
    output word_t             w2,
    output word_t             w3
);
    assign w0 = {s15_hi, s14_lo};
    assign w1 = {s11_lo, s9_hi};
    assign w2 = {s7_lo,  s5_hi};
    assign w3 = {s2_lo,  s0_hi};
endmodule

// File: rtl/gfp_lfsr_core.sv
module gfp_lfsr_core
    import gfp_lfsr_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load_en,
    input  logic [N_CELLS*CELL_W-1:0]   load_cells,
    input  logic                        step_en,
    input  logic                        init_mode,
    input  logic [CELL_W-1:0]           u_in,
    output logic [WORD_W-1:0]           x0,
    output logic [WORD_W-1:0]           x1,
    output logic [WORD_W-1:0]           x2,
    output logic [WORD_W-1:0]           x3
);
    localparam int unsigned HI_LSB = CELL_W - HALF_W;

    lfsr_state_t state_d, state_q;
    cell_t       fb_val;
    cell_t       u_eff;

    assign u_eff = init_mode ? u_in : '0;

    gfp_feedback #(.N_TERMS(8)) i_fb (
        .s15_in(state_q.cells[15]),
        .s13_in(state_q.cells[13]),
        .s10_in(state_q.cells[10]),
        .s4_in (state_q.cells[4]),
        .s0_in (state_q.cells[0]),
        .add_in(u_eff),
        .fb_out(fb_val)
    );

    always_comb begin
        state_d = state_q;
        if (load_en) begin
            state_d.cells = cell_arr_t'(load_cells);
        end else if (step_en) begin
            for (int i = 0; i < N_CELLS - 1; i++) begin
                state_d.cells[i] = state_q.cells[i+1];
            end
            state_d.cells[N_CELLS-1] = fb_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    gfp_reorg i_reorg (
        .s15_hi(state_q.cells[15][CELL_W-1:HI_LSB]),
        .s14_lo(state_q.cells[14][HALF_W-1:0]),
        .s11_lo(state_q.cells[11][HALF_W-1:0]),
        .s9_hi (state_q.cells[9][CELL_W-1:HI_LSB]),
        .s7_lo (state_q.cells[7][HALF_W-1:0]),
        .s5_hi (state_q.cells[5][CELL_W-1:HI_LSB]),
        .s2_lo (state_q.cells[2][HALF_W-1:0]),
        .s0_hi (state_q.cells[0][CELL_W-1:HI_LSB]),
        .w0    (x0),
        .w1    (x1),
        .w2    (x2),
        .w3    (x3)
    );

    // load is written whole and overrides a concurrent step (R2, R3)
    assert_load_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (state_q.cells == cell_arr_t'($past(load_cells))));

    // shift toward cell 0 on a step (R4)
    assert_shift_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load_en) |=>
            (state_q.cells[N_CELLS-2:0] == $past(state_q.cells[N_CELLS-1:1])));

    // stepped-in value is a canonical residue (R7)
    assert_canonical_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load_en) |=> (state_q.cells[N_CELLS-1] != PRIME));

    // idle cycles keep the cells (R11)
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !load_en) |=> $stable(state_q.cells));
endmodule

// File: tb/test_gfp_lfsr_core.sv
module test_gfp_lfsr_core;
    localparam longint unsigned P = 64'h7FFF_FFFF;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_en = 1'b0;
    logic [495:0] load_cells = '0;
    logic         step_en = 1'b0;
    logic         init_mode = 1'b0;
    logic [30:0]  u_in = '0;
    logic [31:0]  x0, x1, x2, x3;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    longint unsigned m [16];

    always #5 clk = ~clk;

    gfp_lfsr_core i_gfp_lfsr_core (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_cells(load_cells),
        .step_en(step_en), .init_mode(init_mode), .u_in(u_in),
        .x0(x0), .x1(x1), .x2(x2), .x3(x3)
    );

    function automatic logic [31:0] hi16(longint unsigned v);
        return 32'((v >> 15) & 64'hFFFF);
    endfunction
    function automatic logic [31:0] lo16(longint unsigned v);
        return 32'(v & 64'hFFFF);
    endfunction

    task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic compare(string tag);
        chk(tag, "x0 R8", x0, (hi16(m[15]) << 16) | lo16(m[14]));
        chk(tag, "x1 R9", x1, (lo16(m[11]) << 16) | hi16(m[9]));
        chk(tag, "x2 R9", x2, (lo16(m[7]) << 16) | hi16(m[5]));
        chk(tag, "x3 R10", x3, (lo16(m[2]) << 16) | hi16(m[0]));
    endtask

    function automatic longint unsigned model_fb(bit im, longint unsigned u);
        longint unsigned v;
        v = (64'd1 << 15) * m[15] + (64'd1 << 17) * m[13] + (64'd1 << 21) * m[10]
          + (64'd1 << 20) * m[4] + 64'd257 * m[0] + (im ? u : 64'd0);
        return v % P;
    endfunction

    // one clock: drive after negedge, update model at posedge, compare at next negedge
    task automatic cyc(string tag, bit ld, logic [495:0] data, bit st, bit im, logic [30:0] u);
        longint unsigned nv;
        load_en = ld; load_cells = data; step_en = st; init_mode = im; u_in = u;
        @(posedge clk);
        if (ld) begin
            for (int i = 0; i < 16; i++) m[i] = longint'(data[31*i +: 31]);
        end else if (st) begin
            nv = model_fb(im, longint'(u));
            for (int i = 0; i < 15; i++) m[i] = m[i+1];
            m[15] = nv;
        end
        @(negedge clk);
        compare(tag);
    endtask

    function automatic logic [495:0] rand_cells();
        logic [495:0] d;
        for (int i = 0; i < 16; i++) d[31*i +: 31] = 31'($urandom());
        return d;
    endfunction

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [495:0] d;
        for (int i = 0; i < 16; i++) m[i] = 0;
        repeat (3) @(negedge clk);
        compare("R1 in reset");
        rst_n = 1'b1;
        cyc("R1 after reset", 1'b0, '0, 1'b0, 1'b0, '0);
        // zero state in working mode stays zero even with u present (R5)
        cyc("R5 zero state ignores u", 1'b0, '0, 1'b1, 1'b0, 31'h1234_5678);
        // init mode with zero cells: new cell equals u (R6)
        cyc("R6 u enters", 1'b0, '0, 1'b1, 1'b1, 31'h5A5A_1234);
        // u == p is congruent to zero: canonical 0 (R7)
        cyc("R2 zero load", 1'b1, '0, 1'b0, 1'b0, '0);
        cyc("R7 u equals p", 1'b0, '0, 1'b1, 1'b1, 31'h7FFF_FFFF);
        // all cells p: every term congruent to zero (R7)
        cyc("R2 all ones load", 1'b1, {496{1'b1}}, 1'b0, 1'b0, '0);
        cyc("R7 all ones step", 1'b0, '0, 1'b1, 1'b0, '0);
        // all cells p-1: heavy wraparound
        for (int i = 0; i < 16; i++) d[31*i +: 31] = 31'h7FFF_FFFE;
        cyc("R2 max load", 1'b1, d, 1'b0, 1'b0, '0);
        for (int k = 0; k < 8; k++) cyc("R4 R5 max wrap", 1'b0, '0, 1'b1, 1'b0, '0);
        for (int r = 0; r < 4; r++) begin
            cyc("R2 random load", 1'b1, rand_cells(), 1'b0, 1'b0, '0);
            for (int k = 0; k < 33; k++)
                cyc("R4 R6 init steps", 1'b0, '0, 1'b1, 1'b1, 31'($urandom()));
            for (int k = 0; k < 20; k++)
                cyc("R4 R5 work steps", 1'b0, '0, 1'b1, 1'b0, 31'($urandom()));
            for (int k = 0; k < 3; k++)
                cyc("R11 idle", 1'b0, rand_cells(), 1'b0, k[0], 31'($urandom()));
            cyc("R3 load beats step", 1'b1, rand_cells(), 1'b1, 1'b1, 31'($urandom()));
            cyc("R4 R5 after load", 1'b0, '0, 1'b1, 1'b0, '0);
        end
        // synchronous reset clears loaded state (R1)
        rst_n = 1'b0;
        @(posedge clk);
        for (int i = 0; i < 16; i++) m[i] = 0;
        @(negedge clk);
        compare("R1 re-reset");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule